// File: doc/BRIEF.md
# Three-Wire Serial Display Link Slave

This block is the slave end of a serial link driven by a host over a chip select, a write strobe, a read strobe and one data line. The data line is split at the block edge into an input, an output and an output enable, so a pad outside the block forms the bidirectional pin. All four link pins are asynchronous to the block clock. They are passed through a synchronizer and their edges are detected on a fast system clock.

Each select window opens with a three-bit mode ID. The ID leads to one of three phases:
- a stream of nine-bit configuration commands;
- an address followed by nibble reads from an external 32x4 display memory;
- an address followed by nibble writes to that memory, or read-modify-writes.

The memory address advances by one after every nibble. Each command word becomes a setting register or a single-cycle pulse for the display, timer, watchdog and tone logic around the block.

Top module: `sdi_link`

## Requirements
- R1: A high level on the chip select discards any partly shifted ID, address, nibble or command. The next transfer must start again with a mode ID after the select goes low.
- R2: The mode ID is sampled on three write-strobe rising edges, first bit first. 100 selects commands, 110 selects memory read, and 101 selects memory write or read-modify-write. Any other ID makes the block ignore the rest of the window: no memory write and no setting change.
- R3: After a 110 or 101 ID, six address bits follow, most significant first. The top address bit is dropped, so the memory address is 5 bits. Write data nibbles follow least significant bit first. Each complete nibble raises `mem_we` for exactly one cycle, with that address and the nibble.
- R4: After every nibble the address rises by one, with no new header. Address 31 is followed by 0.
- R5: In a read window, each falling edge of the read strobe puts the next bit of the current nibble on `ser_dout` with `ser_doe` high, bit 0 first. After the fourth bit, the address moves on.
- R6: In a 101 window, read-strobe falling edges first present the stored bits of the current address, bit 0 first. The four write bits that follow are then stored back to that same address, and only then does the address advance.
- R7: Commands are nine bits, first bit first, and only the first eight are decoded. Further commands in the same window follow at once, without repeating 100.
- R8: Codes are given as the first eight bits:
  - 0000_0000 clears `sys_en` and 0000_0001 sets it.
  - 0000_0010 clears `lcd_on` and 0000_0011 sets it.
  - 0000_1000 clears `tone_on` and 0000_1001 sets it.
- R9: Timer and watchdog codes:
  - 0000_0110 sets `tmr_en` and clears `wdt_en`.
  - 0000_0111 sets `wdt_en` and clears `tmr_en`.
  - 0000_0100 clears `tmr_en` and 0000_0101 clears `wdt_en`.
  - 0000_1101 gives a one-cycle `clr_tmr_p` and 0000_1111 gives a one-cycle `clr_wdt_p`.
  - `tmr_en` and `wdt_en` are never both high.
- R10: 0001_ssXX with ss not 00 loads `clk_src` with ss (01 crystal, 10 internal RC, 11 external). 0010_abXc loads `com_sel` with ab and `bias_third` with c. A code with ab = 11 leaves both unchanged.
- R11: Tone, IRQ and frequency codes:
  - 010X_XXXX clears `tone_2k` and 011X_XXXX sets it.
  - 100X_eXXX loads `irq_en` with e.
  - 101X_Xfff loads `freq_code` with fff.
- R12: After reset the settings are: `sys_en`, `lcd_on`, `tmr_en`, `wdt_en`, `tone_on`, `irq_en` and `tone_2k` all 0; `clk_src` 10; `com_sel` 00; `bias_third` 0; `freq_code` 000; `ser_doe` 0.
- R13: `ser_doe` stays low during the ID, address and write phases. It goes high only once a read strobe has delivered data, and it drops after the chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that oversamples the link |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Chip select, active low |
| ser_wr_n | input | 1 | Write strobe; data are taken on its rising edge |
| ser_rd_n | input | 1 | Read strobe; data are driven on its falling edge |
| ser_din | input | 1 | Data line input from the pad |
| ser_dout | output | 1 | Data line output value |
| ser_doe | output | 1 | Data line output enable |
| mem_addr | output | ADDR_W | Display memory address |
| mem_we | output | 1 | One-cycle memory write pulse |
| mem_wdata | output | 4 | Memory write nibble |
| mem_rdata | input | 4 | Memory read nibble, combinational from mem_addr |
| sys_en | output | 1 | System enable setting |
| lcd_on | output | 1 | LCD bias enable setting |
| tmr_en | output | 1 | Time base routed to the interrupt pin |
| wdt_en | output | 1 | Watchdog flag routed to the interrupt pin |
| tone_on | output | 1 | Tone output enable |
| tone_2k | output | 1 | Tone pitch select, 1 for the lower pitch |
| irq_en | output | 1 | Interrupt pin enable |
| clk_src | output | 2 | Clock source select |
| bias_third | output | 1 | One-third bias select |
| com_sel | output | 2 | Number of commons select |
| freq_code | output | 3 | Time base and watchdog divider code |
| clr_tmr_p | output | 1 | Pulse that clears the time base |
| clr_wdt_p | output | 1 | Pulse that clears the watchdog |

## Verification
The bench uses the default build: a 5-bit memory address and a two-stage synchronizer. With a 32-entry memory, a burst of four nibbles started at address 30 crosses the wrap point. The same 30 start also has the dropped sixth address bit set, so one short burst checks both the wrap and the dropped bit. The two-stage synchronizer fixes the latency from a strobe edge to its effect at three clock cycles. That latency lets the bench hold every strobe phase for a few cycles and still sample each result at a known time.

// File: rtl/sdi_pkg.sv
// Shared definitions for the serial display link.
// Assumes the link framing is fixed: 3-bit IDs, 9-bit commands,
// 6-bit address field and 4-bit data nibbles.
package sdi_pkg;
    localparam int ID_W    = 3;
    localparam int CMD_W   = 9;
    localparam int NIB_W   = 4;
    localparam int AFLD_W  = 6;

    localparam logic [ID_W-1:0] ID_CMD   = 3'b100;
    localparam logic [ID_W-1:0] ID_READ  = 3'b110;
    localparam logic [ID_W-1:0] ID_WRITE = 3'b101;

    typedef enum logic [2:0] {
        ST_ID,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_HALT
    } link_st_t;
endpackage

// File: rtl/sdi_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// It also provides a one-cycle delayed copy of the output for edge detection.
// Assumes every pin is held stable for longer than STAGES+1 clock cycles.
module sdi_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= d;
                end
            end else begin : g_next
                // Pass the value on from the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

    // Hold the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_d <= RST_VAL;
        else        q_d <= q;
    end
endmodule

// File: rtl/sdi_cmd_dec.sv
// Turns each completed 9-bit command word into setting registers and
// one-cycle clear pulses. Only the first eight bits are looked at.
// Assumes cmd_valid is a single-cycle strobe.
module sdi_cmd_dec
    import sdi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             sys_en,
    output logic             lcd_on,
    output logic             tmr_en,
    output logic             wdt_en,
    output logic             tone_on,
    output logic             tone_2k,
    output logic             irq_en,
    output logic [1:0]       clk_src,
    output logic             bias_third,
    output logic [1:0]       com_sel,
    output logic [2:0]       freq_code,
    output logic             clr_tmr_p,
    output logic             clr_wdt_p
);
    logic [3:0] hi;
    logic [3:0] lo;

    assign hi = cmd_word[8:5];
    assign lo = cmd_word[4:1];

    // Apply a decoded command to the settings and produce the clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_en     <= 1'b0;
            lcd_on     <= 1'b0;
            tmr_en     <= 1'b0;
            wdt_en     <= 1'b0;
            tone_on    <= 1'b0;
            tone_2k    <= 1'b0;
            irq_en     <= 1'b0;
            clk_src    <= 2'b10;
            bias_third <= 1'b0;
            com_sel    <= 2'b00;
            freq_code  <= 3'b000;
            clr_tmr_p  <= 1'b0;
            clr_wdt_p  <= 1'b0;
        end else begin
            clr_tmr_p <= 1'b0;
            clr_wdt_p <= 1'b0;
            if (cmd_valid) begin
                casez (hi)
                    4'b0000: begin
                        case (lo)
                            4'h0: sys_en  <= 1'b0;
                            4'h1: sys_en  <= 1'b1;
                            4'h2: lcd_on  <= 1'b0;
                            4'h3: lcd_on  <= 1'b1;
                            4'h4: tmr_en  <= 1'b0;
                            4'h5: wdt_en  <= 1'b0;
                            4'h6: begin tmr_en <= 1'b1; wdt_en <= 1'b0; end
                            4'h7: begin wdt_en <= 1'b1; tmr_en <= 1'b0; end
                            4'h8: tone_on <= 1'b0;
                            4'h9: tone_on <= 1'b1;
                            4'hD: clr_tmr_p <= 1'b1;
                            4'hF: clr_wdt_p <= 1'b1;
                            default: ;
                        endcase
                    end
                    4'b0001: if (lo[3:2] != 2'b00) clk_src <= lo[3:2];
                    4'b0010: begin
                        if (lo[3:2] != 2'b11) begin
                            com_sel    <= lo[3:2];
                            bias_third <= lo[0];
                        end
                    end
                    4'b010?: tone_2k   <= 1'b0;
                    4'b011?: tone_2k   <= 1'b1;
                    4'b100?: irq_en    <= lo[3];
                    4'b101?: freq_code <= lo[2:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdi_link.sv
// Slave side of the three-wire serial display link.
// It decodes the mode ID, then runs command, read, write or
// read-modify-write phases against an external 32x4 memory.
// Assumes mem_rdata follows mem_addr combinationally, and that
// link pins are slow compared with clk.
module sdi_link
    import sdi_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_cs_n,
    input  logic              ser_wr_n,
    input  logic              ser_rd_n,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_doe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [NIB_W-1:0]  mem_wdata,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              sys_en,
    output logic              lcd_on,
    output logic              tmr_en,
    output logic              wdt_en,
    output logic              tone_on,
    output logic              tone_2k,
    output logic              irq_en,
    output logic [1:0]        clk_src,
    output logic              bias_third,
    output logic [1:0]        com_sel,
    output logic [2:0]        freq_code,
    output logic              clr_tmr_p,
    output logic              clr_wdt_p
);
    localparam int CNT_W = $clog2(CMD_W) + 1;
    localparam int IDX_W = $clog2(NIB_W);

    logic [3:0] pins_s;
    logic [3:0] pins_d;
    logic       cs_s;
    logic       din_s;
    logic       wr_rise;
    logic       rd_fall;

    link_st_t            state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [ID_W-2:0]     id_sh;
    logic [CMD_W-2:0]    cmd_sh;
    logic                rd_mode;
    logic [ADDR_W-1:0]   addr;
    logic [NIB_W-2:0]    nib_sh;
    logic [IDX_W-1:0]    rd_idx;
    logic                dout_q;
    logic                doe_q;
    logic                we_q;
    logic [NIB_W-1:0]    wdata_q;
    logic                cmd_valid;
    logic [CMD_W-1:0]    cmd_word;

    sdi_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'hF)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_cs_n, ser_wr_n, ser_rd_n, ser_din}),
        .q     (pins_s),
        .q_d   (pins_d)
    );

    assign cs_s    = pins_s[3];
    assign din_s   = pins_s[0];
    assign wr_rise = pins_s[2] & ~pins_d[2];
    assign rd_fall = ~pins_s[1] & pins_d[1];

    // Link state machine: ID, command, address and data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ID;
            bit_cnt   <= '0;
            id_sh     <= '0;
            cmd_sh    <= '0;
            rd_mode   <= 1'b0;
            addr      <= '0;
            nib_sh    <= '0;
            rd_idx    <= '0;
            dout_q    <= 1'b0;
            doe_q     <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            we_q      <= 1'b0;
            cmd_valid <= 1'b0;
            if (we_q) addr <= addr + 1'b1;
            if (cs_s) begin
                state   <= ST_ID;
                bit_cnt <= '0;
                rd_idx  <= '0;
                doe_q   <= 1'b0;
            end else if (wr_rise) begin
                case (state)
                    ST_ID: begin
                        id_sh <= {id_sh[0], din_s};
                        if (bit_cnt == CNT_W'(ID_W - 1)) begin
                            bit_cnt <= '0;
                            case ({id_sh, din_s})
                                ID_CMD:   state <= ST_CMD;
                                ID_READ:  begin state <= ST_ADDR; rd_mode <= 1'b1; end
                                ID_WRITE: begin state <= ST_ADDR; rd_mode <= 1'b0; end
                                default:  state <= ST_HALT;
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_CMD: begin
                        cmd_sh <= {cmd_sh[CMD_W-3:0], din_s};
                        if (bit_cnt == CNT_W'(CMD_W - 1)) begin
                            bit_cnt   <= '0;
                            cmd_valid <= 1'b1;
                            cmd_word  <= {cmd_sh, din_s};
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr <= {addr[ADDR_W-2:0], din_s};
                        if (bit_cnt == CNT_W'(AFLD_W - 1)) begin
                            bit_cnt <= '0;
                            rd_idx  <= '0;
                            state   <= rd_mode ? ST_RDATA : ST_WDATA;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        doe_q  <= 1'b0;
                        nib_sh <= {din_s, nib_sh[NIB_W-2:1]};
                        if (bit_cnt == CNT_W'(NIB_W - 1)) begin
                            bit_cnt <= '0;
                            rd_idx  <= '0;
                            we_q    <= 1'b1;
                            wdata_q <= {din_s, nib_sh};
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (rd_fall) begin
                case (state)
                    ST_RDATA: begin
                        dout_q <= mem_rdata[rd_idx];
                        doe_q  <= 1'b1;
                        rd_idx <= rd_idx + 1'b1;
                        if (rd_idx == IDX_W'(NIB_W - 1)) addr <= addr + 1'b1;
                    end
                    ST_WDATA: begin
                        dout_q <= mem_rdata[rd_idx];
                        doe_q  <= 1'b1;
                        rd_idx <= rd_idx + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ser_dout  = dout_q;
    assign ser_doe   = doe_q;
    assign mem_addr  = addr;
    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;

    sdi_cmd_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .sys_en     (sys_en),
        .lcd_on     (lcd_on),
        .tmr_en     (tmr_en),
        .wdt_en     (wdt_en),
        .tone_on    (tone_on),
        .tone_2k    (tone_2k),
        .irq_en     (irq_en),
        .clk_src    (clk_src),
        .bias_third (bias_third),
        .com_sel    (com_sel),
        .freq_code  (freq_code),
        .clr_tmr_p  (clr_tmr_p),
        .clr_wdt_p  (clr_wdt_p)
    );
endmodule

// File: rtl/sdi_link_chk.sv
// Property checker for sdi_link. It is attached through bind below.
// Assumes the synchronized chip select and the output ports.
module sdi_link_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              ser_doe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              tmr_en,
    input logic              wdt_en,
    input logic              clr_tmr_p,
    input logic              clr_wdt_p
);
    // R13: the output enable drops after the select goes high.
    a_r13_doe_released: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !ser_doe);

    // R3: a memory write lasts exactly one cycle.
    a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: the address steps by one, with wrap, after each write.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R9: the interrupt source selections are mutually exclusive.
    a_r9_src_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_en && wdt_en));

    // R9: the clear pulses last one cycle.
    a_r9_clr_tmr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tmr_p |=> !clr_tmr_p);
    a_r9_clr_wdt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wdt_p |=> !clr_wdt_p);
endmodule

bind sdi_link sdi_link_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .ser_doe   (ser_doe),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .tmr_en    (tmr_en),
    .wdt_en    (wdt_en),
    .clr_tmr_p (clr_tmr_p),
    .clr_wdt_p (clr_wdt_p)
);

// File: tb/sdi_link_tb.sv
// Scoreboard bench for sdi_link. Driver tasks queue the expected read
// bits and memory writes; monitors pop and compare them.
module sdi_link_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1, ser_wr_n = 1'b1, ser_rd_n = 1'b1, ser_din = 1'b1;
    logic ser_dout, ser_doe;
    logic [4:0] mem_addr;
    logic mem_we;
    logic [3:0] mem_wdata, mem_rdata;
    logic sys_en, lcd_on, tmr_en, wdt_en, tone_on, tone_2k, irq_en;
    logic [1:0] clk_src, com_sel;
    logic bias_third;
    logic [2:0] freq_code;
    logic clr_tmr_p, clr_wdt_p;

    int tests = 0;
    int fails = 0;
    int n_clr_tmr = 0;
    int n_clr_wdt = 0;

    logic [3:0] ram    [32];
    logic [3:0] shadow [32];
    logic       exp_rd [$];
    string      exp_rd_tag [$];
    logic [8:0] exp_wr [$];

    always #5 clk = ~clk;

    sdi_link u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_cs_n(ser_cs_n), .ser_wr_n(ser_wr_n), .ser_rd_n(ser_rd_n), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_doe(ser_doe),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sys_en(sys_en), .lcd_on(lcd_on), .tmr_en(tmr_en), .wdt_en(wdt_en),
        .tone_on(tone_on), .tone_2k(tone_2k), .irq_en(irq_en), .clk_src(clk_src),
        .bias_third(bias_third), .com_sel(com_sel), .freq_code(freq_code),
        .clr_tmr_p(clr_tmr_p), .clr_wdt_p(clr_wdt_p)
    );

    // Memory model outside the block.
    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) ram[i] <= 4'h0;
        end else if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Write monitor: compare every memory write with the queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R2", "unexpected memory write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [8:0] e;
                e = exp_wr.pop_front();
                check({mem_addr, mem_wdata} == e, "R3", "write addr/data",
                      {mem_addr, mem_wdata}, e);
            end
        end
    end

    // Read monitor: sample the data line while the read strobe is low.
    always @(negedge ser_rd_n) begin
        repeat (6) @(negedge clk);
        if (exp_rd.size() == 0) begin
            check(1'b0, "R5", "unexpected read strobe", ser_dout, 0);
        end else begin
            logic  e;
            string t;
            e = exp_rd.pop_front();
            t = exp_rd_tag.pop_front();
            check(ser_dout === e && ser_doe === 1'b1, t, "read bit {doe,dout}",
                  {ser_doe, ser_dout}, {1'b1, e});
        end
    end

    // Count the clear pulses.
    always @(negedge clk) begin
        if (rst_n && clr_tmr_p) n_clr_tmr++;
        if (rst_n && clr_wdt_p) n_clr_wdt++;
    end

    task automatic wr_bit(input logic b);
        @(negedge clk);
        ser_din  = b;
        ser_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        ser_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic rd_bit(input logic e, input string tag);
        @(negedge clk);
        exp_rd.push_back(e);
        exp_rd_tag.push_back(tag);
        ser_rd_n = 1'b0;
        repeat (10) @(negedge clk);
        ser_rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_open();
        @(negedge clk);
        ser_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_close();
        @(negedge clk);
        ser_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_bits(input logic [8:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic send_cmd(input logic [7:0] code, input logic last);
        send_bits({code, last}, 9);
        repeat (3) @(negedge clk);
    endtask

    task automatic write_burst(input logic [5:0] a, input int n, input int seed);
        cs_open();
        send_bits(9'b101, 3);
        send_bits({3'b0, a}, 6);
        for (int k = 0; k < n; k++) begin
            logic [4:0] x;
            logic [3:0] d;
            x = a[4:0] + 5'(k);
            d = 4'(seed + 3 * k + 1);
            exp_wr.push_back({x, d});
            shadow[x] = d;
            for (int j = 0; j < 4; j++) wr_bit(d[j]);
        end
        cs_close();
    endtask

    task automatic read_burst(input logic [5:0] a, input int n);
        cs_open();
        send_bits(9'b110, 3);
        send_bits({3'b0, a}, 6);
        check(ser_doe == 1'b0, "R13", "doe before read strobe", ser_doe, 0);
        for (int k = 0; k < n; k++) begin
            logic [4:0] x;
            x = a[4:0] + 5'(k);
            for (int j = 0; j < 4; j++) rd_bit(shadow[x][j], "R5");
        end
        cs_close();
        check(ser_doe == 1'b0, "R13", "doe after select high", ser_doe, 0);
    endtask

    task automatic rmw_burst(input logic [5:0] a, input int n);
        cs_open();
        send_bits(9'b101, 3);
        send_bits({3'b0, a}, 6);
        for (int k = 0; k < n; k++) begin
            logic [4:0] x;
            logic [3:0] nd;
            x = a[4:0] + 5'(k);
            for (int j = 0; j < 4; j++) rd_bit(shadow[x][j], "R6");
            nd = ~shadow[x];
            exp_wr.push_back({x, nd});
            shadow[x] = nd;
            for (int j = 0; j < 4; j++) wr_bit(nd[j]);
        end
        cs_close();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = 4'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12: reset values.
        check({sys_en, lcd_on, tmr_en, wdt_en, tone_on, irq_en, tone_2k} == 7'b0,
              "R12", "enable flags", {sys_en, lcd_on, tmr_en, wdt_en, tone_on, irq_en, tone_2k}, 0);
        check(clk_src == 2'b10 && com_sel == 2'b00 && bias_third == 1'b0, "R12",
              "clock/lcd setup", {clk_src, com_sel, bias_third}, 5'b10000);
        check(freq_code == 3'b000 && ser_doe == 1'b0, "R12", "freq/doe",
              {freq_code, ser_doe}, 0);

        // R7 R8: consecutive commands without repeating the ID, last bit varied.
        cs_open();
        send_bits(9'b100, 3);
        send_cmd(8'b0000_0001, 1'b1);
        send_cmd(8'b0000_0011, 1'b0);
        send_cmd(8'b0000_1001, 1'b1);
        cs_close();
        check(sys_en && lcd_on && tone_on, "R8", "sys/lcd/tone on",
              {sys_en, lcd_on, tone_on}, 3'b111);

        // R9: timer and watchdog controls and clear pulses.
        cs_open();
        send_bits(9'b100, 3);
        send_cmd(8'b0000_0110, 1'b0);
        check(tmr_en == 1'b1 && wdt_en == 1'b0, "R9", "timer enable", {tmr_en, wdt_en}, 2'b10);
        send_cmd(8'b0000_0111, 1'b0);
        check(tmr_en == 1'b0 && wdt_en == 1'b1, "R9", "wdt enable", {tmr_en, wdt_en}, 2'b01);
        send_cmd(8'b0000_0101, 1'b0);
        check(wdt_en == 1'b0, "R9", "wdt disable", wdt_en, 0);
        send_cmd(8'b0000_1101, 1'b0);
        send_cmd(8'b0000_1111, 1'b0);
        cs_close();
        check(n_clr_tmr == 1 && n_clr_wdt == 1, "R9", "clear pulse counts",
              {n_clr_tmr[3:0], n_clr_wdt[3:0]}, 8'h11);

        // R10: clock source and bias/commons, including the ignored ab=11 case.
        cs_open();
        send_bits(9'b100, 3);
        send_cmd(8'b0001_1100, 1'b0);
        send_cmd(8'b0010_1001, 1'b0);
        send_cmd(8'b0010_1100, 1'b0);
        send_cmd(8'b0001_0000, 1'b0);
        cs_close();
        check(clk_src == 2'b11, "R10", "clock source", clk_src, 3);
        check(com_sel == 2'b10 && bias_third == 1'b1, "R10", "commons/bias kept",
              {com_sel, bias_third}, 3'b101);

        // R11: tone pitch, irq enable, frequency code.
        cs_open();
        send_bits(9'b100, 3);
        send_cmd(8'b0110_0000, 1'b0);
        send_cmd(8'b1000_1000, 1'b0);
        send_cmd(8'b1010_0101, 1'b0);
        cs_close();
        check(tone_2k && irq_en && freq_code == 3'd5, "R11", "tone/irq/freq",
              {tone_2k, irq_en, freq_code}, 5'b11101);
        cs_open();
        send_bits(9'b100, 3);
        send_cmd(8'b0100_0000, 1'b1);
        cs_close();
        check(tone_2k == 1'b0, "R11", "tone back to higher pitch", tone_2k, 0);

        // R1: an aborted command has no effect; a new window needs an ID.
        cs_open();
        send_bits(9'b100, 3);
        send_bits(9'b000000000, 5);
        cs_close();
        check(sys_en == 1'b1, "R1", "partial command ignored", sys_en, 1);
        cs_open();
        send_bits(9'b100, 3);
        send_cmd(8'b0000_0010, 1'b0);
        cs_close();
        check(lcd_on == 1'b0, "R1", "fresh window after abort", lcd_on, 0);

        // R2: unknown IDs ignore the whole window.
        cs_open();
        send_bits(9'b111, 3);
        send_bits(9'b000000011, 9);
        send_bits(9'b000000011, 9);
        cs_close();
        cs_open();
        send_bits(9'b011, 3);
        send_bits(9'b000000011, 9);
        cs_close();
        check(lcd_on == 1'b0 && exp_wr.size() == 0, "R2", "bad ID has no effect", lcd_on, 0);

        // R3 R4: write burst with A5 set (address 30), wrapping past 31.
        write_burst(6'b111110, 4, 5);
        check(exp_wr.size() == 0, "R4", "all wrapped writes seen", exp_wr.size(), 0);

        // R5: read back across the wrap.
        read_burst(6'b011110, 4);

        // R3: aborted nibble is not written.
        cs_open();
        send_bits(9'b101, 3);
        send_bits(9'd9, 6);
        wr_bit(1'b1);
        wr_bit(1'b0);
        cs_close();

        // R6: read-modify-write on addresses 9 and 10.
        write_burst(6'd9, 2, 11);
        rmw_burst(6'd9, 2);
        read_burst(6'd9, 2);

        repeat (20) @(negedge clk);
        check(exp_wr.size() == 0, "R3", "pending expected writes", exp_wr.size(), 0);
        check(exp_rd.size() == 0, "R5", "pending expected reads", exp_rd.size(), 0);
        check(ser_doe == 1'b0, "R13", "doe idle at end", ser_doe, 0);

        summary();
        $finish;
    end
endmodule